// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block turns single read and write requests into the command sequence one DRAM bank needs: open a row, issue a column access, and close the row again by precharging. Row and column share one address bus. A row stays open after its access, so a later request to the same row goes straight to the column command. A request to another row first precharges the bank and then opens the new row. The spacing between phases comes from parameters counted in clock cycles: activate to column, precharge to activate, read latency and write recovery.

Requests use a valid/ready handshake and carry a row, a column, a direction flag and write data. Only one request is in flight at a time. Read data comes back as a one-cycle response pulse. A separate close input precharges an open row on demand.

Top module: `dram_bank_seq`

## Requirements
- R1: After synchronous reset, req_ready is high, all four command strobes and resp_valid are low, and no row is open, so the first request always starts with an activation.
- R2: The strobes cmd_act, cmd_rd, cmd_wr and cmd_pre are never high together. Each command lasts exactly one cycle.
- R3: A request accepted while no row is open drives cmd_act in the first cycle after the accepting edge, with the row on bank_addr (LSB-aligned, upper bits zero). Its column command follows exactly T_RCD cycles after cmd_act.
- R4: A request to the open row issues its column command (cmd_rd or cmd_wr) in the first cycle after the accepting edge, with no activation or precharge. The column is on bank_addr, LSB-aligned and zero-extended.
- R5: A request to a row other than the open one drives cmd_pre in the first cycle after acceptance, then cmd_act with the new row exactly T_RP cycles later, then the column command exactly T_RCD cycles after that. No activation is ever issued while a row is open.
- R6: A read raises resp_valid for one cycle, exactly T_CL cycles after cmd_rd. resp_data carries the value on rd_data at the clock edge that raises resp_valid. T_CL is at least 2.
- R7: A write drives its data on wr_data in the cmd_wr cycle and leaves the row contents updated. req_ready returns exactly T_WR cycles after cmd_wr.
- R8: req_ready is low from the accepting edge until the request ends. For a read, it is high again in the resp_valid cycle. For a write, it returns as R7 states. No command is issued while req_ready is high.
- R9: close_row asserted while idle with a row open drives cmd_pre in the next cycle. req_ready stays low for T_RP cycles. The next request to the same row starts with an activation, not a precharge.
- R10: close_row asserted while idle with no row open issues no command. req_ready is high again in the first cycle after close_row is released.
- R11: close_row has priority over a request in the same cycle. req_ready is low whenever close_row is high, so no request is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| close_row | input | 1 | Precharge the open row when idle |
| cmd_act | output | 1 | Activate strobe |
| cmd_rd | output | 1 | Column read strobe |
| cmd_wr | output | 1 | Column write strobe |
| cmd_pre | output | 1 | Precharge strobe |
| bank_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| wr_data | output | DATA_W | Write data to the bank, valid with cmd_wr |
| rd_data | input | DATA_W | Read data from the bank |
| resp_valid | output | 1 | Read response pulse |
| resp_data | output | DATA_W | Read response data |

## Verification
The assertions assume a few things about the inputs. All latency parameters are at least one and T_CL is at least two. Reset is held for at least one clock edge. Nothing but this block drives the bank, so the open-row state seen by the checker is the real bank state. They also assume rd_data is already settled when the block samples it, T_CL cycles after the read strobe. The bench stays inside these limits: it uses small legal latencies, a bank model that puts read data on rd_data at the edge after the read strobe and holds it there, and it changes close_row and request inputs only on falling clock edges.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_RDW,
    S_WRW,
    S_CLS
  } seq_state_e;

  typedef enum logic [2:0] {
    C_NOP,
    C_ACT,
    C_RD,
    C_WR,
    C_PRE
  } bank_cmd_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             is_open,
  output logic [ROW_W-1:0] cur_row,
  output logic             hit
);

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      cur_row <= '0;
    end else if (open_en) begin
      is_open <= 1'b1;
      cur_row <= row_in;
    end else if (close_en) begin
      is_open <= 1'b0;
    end
  end

  assign hit = is_open && (cur_row == cmp_row);

endmodule

// File: rtl/dbs_cmd_reg.sv
module dbs_cmd_reg
  import dbs_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_cmd_e         cmd,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] wdata,
  output logic              act_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              pre_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic [ADDR_W-1:0] row_x;
  logic [ADDR_W-1:0] col_x;

  generate
    if (ROW_W < ADDR_W) begin : g_row_pad
      assign row_x = {{(ADDR_W-ROW_W){1'b0}}, row};
    end else begin : g_row_full
      assign row_x = row;
    end
    if (COL_W < ADDR_W) begin : g_col_pad
      assign col_x = {{(ADDR_W-COL_W){1'b0}}, col};
    end else begin : g_col_full
      assign col_x = col;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      pre_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      act_q <= (cmd == C_ACT);
      rd_q  <= (cmd == C_RD);
      wr_q  <= (cmd == C_WR);
      pre_q <= (cmd == C_PRE);
      if (cmd == C_ACT) begin
        addr_q <= row_x;
      end else if ((cmd == C_RD) || (cmd == C_WR)) begin
        addr_q <= col_x;
      end
      if (cmd == C_WR) begin
        wdata_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dbs_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 4,
  parameter int T_RP   = 4,
  parameter int T_CL   = 5,
  parameter int T_WR   = 3
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    req_valid,
  output logic                                    req_ready,
  input  logic [ROW_W-1:0]                        req_row,
  input  logic [COL_W-1:0]                        req_col,
  input  logic                                    req_write,
  input  logic [DATA_W-1:0]                       req_wdata,
  input  logic                                    close_row,
  output logic                                    cmd_act,
  output logic                                    cmd_rd,
  output logic                                    cmd_wr,
  output logic                                    cmd_pre,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] bank_addr,
  output logic [DATA_W-1:0]                       wr_data,
  input  logic [DATA_W-1:0]                       rd_data,
  output logic                                    resp_valid,
  output logic [DATA_W-1:0]                       resp_data
);

  localparam int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LAT_MAX = max_of4(T_RCD, T_RP, T_CL, T_WR);
  localparam int CNT_W   = $clog2(LAT_MAX + 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] CL_LD  = CNT_W'(T_CL - 1);
  localparam logic [CNT_W-1:0] WR_LD  = CNT_W'(T_WR - 1);

  seq_state_e        state_q, state_d;
  bank_cmd_e         cmd_sel;
  logic [ROW_W-1:0]  lat_row, sel_row;
  logic [COL_W-1:0]  lat_col, sel_col;
  logic [DATA_W-1:0] lat_wdata, sel_wdata;
  logic              lat_wr;
  logic              tmr_load, tmr_done;
  logic [CNT_W-1:0]  tmr_val;
  logic              open_en, close_en;
  logic              row_open, row_hit;
  logic [ROW_W-1:0]  open_row;
  logic              resp_fire;
  logic              take;

  assign req_ready = (state_q == S_IDLE) && !close_row;
  assign take      = req_valid && req_ready;

  dbs_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  dbs_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .open_en  (open_en),
    .close_en (close_en),
    .row_in   (sel_row),
    .cmp_row  (req_row),
    .is_open  (row_open),
    .cur_row  (open_row),
    .hit      (row_hit)
  );

  dbs_cmd_reg #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd_sel),
    .row     (sel_row),
    .col     (sel_col),
    .wdata   (sel_wdata),
    .act_q   (cmd_act),
    .rd_q    (cmd_rd),
    .wr_q    (cmd_wr),
    .pre_q   (cmd_pre),
    .addr_q  (bank_addr),
    .wdata_q (wr_data)
  );

  always_comb begin
    state_d   = state_q;
    cmd_sel   = C_NOP;
    sel_row   = lat_row;
    sel_col   = lat_col;
    sel_wdata = lat_wdata;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    open_en   = 1'b0;
    close_en  = 1'b0;
    resp_fire = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (close_row) begin
          if (row_open) begin
            cmd_sel  = C_PRE;
            close_en = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = RP_LD;
            state_d  = S_CLS;
          end
        end else if (req_valid) begin
          sel_row   = req_row;
          sel_col   = req_col;
          sel_wdata = req_wdata;
          if (row_hit) begin
            cmd_sel  = req_write ? C_WR : C_RD;
            tmr_load = 1'b1;
            tmr_val  = req_write ? WR_LD : CL_LD;
            state_d  = req_write ? S_WRW : S_RDW;
          end else if (row_open) begin
            cmd_sel  = C_PRE;
            close_en = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = RP_LD;
            state_d  = S_PRE;
          end else begin
            cmd_sel  = C_ACT;
            open_en  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = RCD_LD;
            state_d  = S_ACT;
          end
        end
      end
      S_PRE: begin
        if (tmr_done) begin
          cmd_sel  = C_ACT;
          open_en  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = RCD_LD;
          state_d  = S_ACT;
        end
      end
      S_ACT: begin
        if (tmr_done) begin
          cmd_sel  = lat_wr ? C_WR : C_RD;
          tmr_load = 1'b1;
          tmr_val  = lat_wr ? WR_LD : CL_LD;
          state_d  = lat_wr ? S_WRW : S_RDW;
        end
      end
      S_RDW: begin
        if (tmr_done) begin
          resp_fire = 1'b1;
          state_d   = S_IDLE;
        end
      end
      S_WRW, S_CLS: begin
        if (tmr_done) begin
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
    end else if (take) begin
      lat_row   <= req_row;
      lat_col   <= req_col;
      lat_wr    <= req_write;
      lat_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= resp_fire;
      if (resp_fire) begin
        resp_data <= rd_data;
      end
    end
  end

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int ROW_W = 13,
  parameter int T_RCD = 4,
  parameter int T_RP  = 4,
  parameter int T_CL  = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             close_row,
  input logic             cmd_act,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_pre,
  input logic [ROW_W-1:0] act_row,
  input logic             resp_valid,
  input logic             row_open,
  input logic [ROW_W-1:0] open_row
);

  localparam int LMAX = (T_RCD > T_RP) ? ((T_RCD > T_CL) ? T_RCD : T_CL)
                                       : ((T_RP > T_CL) ? T_RP : T_CL);
  localparam int SW = $clog2(LMAX + 2) + 1;
  localparam logic [SW-1:0] SAT = {SW{1'b1}};

  logic [SW-1:0] since_act, since_pre, since_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '0;
    end else if (cmd_act) begin
      since_act <= SW'(1);
    end else if (cmd_rd || cmd_wr) begin
      since_act <= '0;
    end else if (since_act != '0 && since_act != SAT) begin
      since_act <= since_act + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_pre <= '0;
    end else if (cmd_pre) begin
      since_pre <= SW'(1);
    end else if (cmd_act) begin
      since_pre <= '0;
    end else if (since_pre != '0 && since_pre != SAT) begin
      since_pre <= since_pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rd <= '0;
    end else if (cmd_rd) begin
      since_rd <= SW'(1);
    end else if (since_rd != '0 && since_rd != SAT) begin
      since_rd <= since_rd + 1'b1;
    end
  end

  assert_cmd_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre}));

  assert_act_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_act |=> !cmd_act);

  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |=> !cmd_rd);

  assert_act_row_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_act |-> (row_open && open_row == act_row));

  assert_rcd_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd || cmd_wr) |-> (since_act == '0 || since_act == SW'(T_RCD)));

  assert_col_needs_row_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd || cmd_wr) |-> row_open);

  assert_act_after_close_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_act |-> !$past(row_open));

  assert_rp_gap_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_act |-> (since_pre == '0 || since_pre >= SW'(T_RP)));

  assert_cl_gap_R6: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (since_rd == SW'(T_CL)));

  assert_resp_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_busy_no_ready_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_act || cmd_rd || cmd_wr || cmd_pre) |-> !req_ready);

  assert_close_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    close_row |-> !req_ready);

endmodule

bind dram_bank_seq dbs_checker #(
  .ROW_W (ROW_W),
  .T_RCD (T_RCD),
  .T_RP  (T_RP),
  .T_CL  (T_CL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .close_row  (close_row),
  .cmd_act    (cmd_act),
  .cmd_rd     (cmd_rd),
  .cmd_wr     (cmd_wr),
  .cmd_pre    (cmd_pre),
  .act_row    (bank_addr[ROW_W-1:0]),
  .resp_valid (resp_valid),
  .row_open   (row_open),
  .open_row   (open_row)
);

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;

  localparam int ROW_W  = 6;
  localparam int COL_W  = 5;
  localparam int DATA_W = 16;
  localparam int T_RCD  = 3;
  localparam int T_RP   = 2;
  localparam int T_CL   = 4;
  localparam int T_WR   = 2;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int NROW   = 1 << ROW_W;
  localparam int NCOL   = 1 << COL_W;

  localparam int EV_ACT  = 1;
  localparam int EV_RD   = 2;
  localparam int EV_WR   = 3;
  localparam int EV_PRE  = 4;
  localparam int EV_RESP = 5;

  typedef struct {
    int    code;
    int    cyc;
    int    val;
    string tag;
  } ev_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic              req_write = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              close_row = 1'b0;
  logic              cmd_act, cmd_rd, cmd_wr, cmd_pre;
  logic [ADDR_W-1:0] bank_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_data;

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  ev_t evq[$];

  logic [DATA_W-1:0] bank_mem [NROW][NCOL];
  logic [DATA_W-1:0] ref_mem  [NROW][NCOL];
  logic [ROW_W-1:0]  bk_row = '0;
  bit                tb_open = 1'b0;
  int                tb_row = 0;

  always #2 clk = ~clk;

  dram_bank_seq #(
    .ROW_W (ROW_W), .COL_W (COL_W), .DATA_W (DATA_W),
    .T_RCD (T_RCD), .T_RP (T_RP), .T_CL (T_CL), .T_WR (T_WR)
  ) uut (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_row (req_row), .req_col (req_col),
    .req_write (req_write), .req_wdata (req_wdata),
    .close_row (close_row),
    .cmd_act (cmd_act), .cmd_rd (cmd_rd), .cmd_wr (cmd_wr), .cmd_pre (cmd_pre),
    .bank_addr (bank_addr), .wr_data (wr_data), .rd_data (rd_data),
    .resp_valid (resp_valid), .resp_data (resp_data)
  );

  function automatic logic [DATA_W-1:0] seed_val(input int r, input int c);
    return DATA_W'(r * 131 + c * 29 + 'h3c5);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural bank: latches the row on activate, returns data the edge after a read.
  always @(posedge clk) begin
    if (cmd_act) bk_row <= bank_addr[ROW_W-1:0];
    if (cmd_rd)  rd_data <= bank_mem[bk_row][bank_addr[COL_W-1:0]];
    if (cmd_wr)  bank_mem[bk_row][bank_addr[COL_W-1:0]] <= wr_data;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int code, input int c, input int val, input string tag);
    ev_t e;
    e.code = code; e.cyc = c; e.val = val; e.tag = tag;
    evq.push_back(e);
  endtask

  task automatic observe(input int code, input int val);
    ev_t e;
    checks++;
    if (evq.size() == 0) begin
      errors++;
      $display("FAIL R2 unexpected event: actual code %0d cycle %0d val %0h expected none",
               code, cyc, val);
    end else begin
      e = evq.pop_front();
      if (e.code != code || e.cyc != cyc || e.val != val) begin
        errors++;
        $display("FAIL %s event: actual code %0d cycle %0d val %0h expected code %0d cycle %0d val %0h",
                 e.tag, code, cyc, val, e.code, e.cyc, e.val);
      end
    end
  endtask

  // Monitor: compares every bank command and response against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_act)    observe(EV_ACT, int'(bank_addr));
      if (cmd_rd)     observe(EV_RD, int'(bank_addr));
      if (cmd_wr)     observe(EV_WR, int'(bank_addr) * 65536 + int'(wr_data));
      if (cmd_pre)    observe(EV_PRE, 0);
      if (resp_valid) observe(EV_RESP, int'(resp_data));
    end
  end

  task automatic do_req(input int row, input int col, input bit wr,
                        input logic [DATA_W-1:0] data, input bit with_close);
    int    a;
    int    colc;
    int    done;
    string ctag;
    @(negedge clk);
    req_valid = 1'b1;
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    req_write = wr;
    req_wdata = data;
    if (with_close) begin
      close_row = 1'b1;
      #1;
      check(req_ready == 1'b0, "R11", "ready with close and request", int'(req_ready), 0);
      push(EV_PRE, cyc + 1, 0, "R11");
      tb_open = 1'b0;
      @(negedge clk);
      close_row = 1'b0;
    end
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    a = cyc + 1;
    if (tb_open && tb_row == row) begin
      colc = a;
      ctag = "R4";
    end else if (tb_open) begin
      push(EV_PRE, a, 0, "R5");
      push(EV_ACT, a + T_RP, row, "R5");
      colc = a + T_RP + T_RCD;
      ctag = "R5";
    end else begin
      push(EV_ACT, a, row, "R3");
      colc = a + T_RCD;
      ctag = "R3";
    end
    if (wr) begin
      push(EV_WR, colc, col * 65536 + int'(data), "R7");
      ref_mem[row][col] = data;
      done = colc + T_WR;
    end else begin
      push(EV_RD, colc, col, ctag);
      push(EV_RESP, colc + T_CL, int'(ref_mem[row][col]), "R6");
      done = colc + T_CL;
    end
    tb_open = 1'b1;
    tb_row  = row;
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    check(cyc == done, wr ? "R7" : "R8", "ready return cycle", cyc, done);
  endtask

  task automatic close_bank();
    int exp_rdy;
    @(negedge clk);
    close_row = 1'b1;
    #1;
    check(req_ready == 1'b0, "R11", "ready while close held", int'(req_ready), 0);
    if (tb_open) begin
      push(EV_PRE, cyc + 1, 0, "R9");
      exp_rdy = cyc + 1 + T_RP;
      tb_open = 1'b0;
      @(negedge clk);
      close_row = 1'b0;
      forever begin
        #1;
        if (req_ready) break;
        @(negedge clk);
      end
      check(cyc == exp_rdy, "R9", "ready after close", cyc, exp_rdy);
    end else begin
      @(negedge clk);
      close_row = 1'b0;
      #1;
      check(req_ready == 1'b1, "R10", "ready after ignored close", int'(req_ready), 1);
      repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual %0d cycles expected fewer", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NROW; r++) begin
      for (int c = 0; c < NCOL; c++) begin
        bank_mem[r][c] = seed_val(r, c);
        ref_mem[r][c]  = seed_val(r, c);
      end
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    check({cmd_act, cmd_rd, cmd_wr, cmd_pre} == 4'b0, "R1", "commands after reset",
          int'({cmd_act, cmd_rd, cmd_wr, cmd_pre}), 0);
    check(resp_valid == 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);

    do_req(5, 3, 1'b0, '0, 1'b0);          // R3 empty bank read
    do_req(5, 7, 1'b1, 16'hbeef, 1'b0);    // R4 hit write
    do_req(5, 7, 1'b0, '0, 1'b0);          // R4 hit read of written data
    do_req(9, 1, 1'b0, '0, 1'b0);          // R5 row conflict
    do_req(9, 31, 1'b1, 16'h1234, 1'b0);   // R7 write at top column
    do_req(63, 31, 1'b0, '0, 1'b0);        // R5 conflict to top row
    close_bank();                          // R9 close with row open
    do_req(63, 31, 1'b0, '0, 1'b0);        // R9 same row reopens by activation
    close_bank();
    close_bank();                          // R10 close with nothing open
    do_req(0, 0, 1'b1, 16'h0f0f, 1'b0);    // R10 next request activates directly
    do_req(0, 0, 1'b0, '0, 1'b0);
    do_req(12, 4, 1'b0, '0, 1'b1);         // R11 close and request together
    for (int i = 0; i < 8; i++) begin
      do_req((i < 4) ? 12 : 40, i * 3, i[0], DATA_W'(i * 4369 + 1), 1'b0);
    end
    do_req(9, 31, 1'b0, '0, 1'b0);         // R7 written data persists across rows
    do_req(40, 21, 1'b0, '0, 1'b0);

    repeat (10) @(negedge clk);
    check(evq.size() == 0, "R6", "events still pending", evq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule